// File: doc/BRIEF.md
# Priority-Label Mailbox Capture Unit

This block sits behind one serial-avionics receiver and pulls selected words aside before they reach the general receive queue. It holds three 8-bit label match values and three mailboxes, each 24 bits wide. When a received word passes the optional sign/status pre-filter and its label byte equals a match value, the 24 bits above the label are written into the mailbox that goes with that match value. The label itself is not stored, because the match value already identifies it.

A host loads all three match values in one three-byte burst. The first byte goes into the highest-numbered register. The host can read the values back at any time. Each mailbox drives its own ready pin and can be routed to a shared interrupt line. The host selects a mailbox to look at, and a read strobe on that selection consumes the mailbox contents.

Top module: `plbox_capture`

## Requirements
- R1: After reset, all match registers read 0x00, all ready flags are 0 and `irq` is 0.
- R2: `ld_start` with `ld_valid` begins a load burst. The byte with the start goes to register 3, the next `ld_valid` byte goes to register 2 and the one after that to register 1. Any further `ld_valid` bytes are ignored until the next `ld_start`.
- R3: `match_rd` always shows the registers: bits [7:0] are register 1, bits [15:8] are register 2 and bits [23:16] are register 3.
- R4: Received words use label = `rx_word[7:0]` and field = `rx_word[31:8]`. When a capture-eligible word's label equals register k, mailbox k holds the field and `box_rdy[k-1]` is 1 in the cycle after `rx_valid`. Mailboxes with no match keep their data and flag.
- R5: While `cfg_cap_en` is 0, no mailbox is written and no ready flag rises.
- R6: While `cfg_sd_en` is 1, a word is eligible only if `rx_word[9:8]` equals `cfg_sd_val`. While `cfg_sd_en` is 0, the S/D bits are not checked.
- R7: A label that equals several registers writes the field into every matching mailbox and sets each of their flags.
- R8: `box_data` shows the mailbox selected by `rd_sel` (0 selects mailbox 1) without side effects. A cycle with `rd_en` high clears the selected flag.
- R9: A capture into a mailbox whose flag is already set replaces the data and leaves the flag set.
- R10: When a capture and a read strobe hit the same mailbox in the same cycle, the new data is kept and the flag stays set.
- R11: `irq` is 1 exactly when some mailbox k has both its ready flag and `cfg_irq_mask[k-1]` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cap_en | input | 1 | Global mailbox capture enable |
| cfg_sd_en | input | 1 | S/D pre-filter enable |
| cfg_sd_val | input | 2 | Required value of word bits [9:8] |
| cfg_irq_mask | input | 3 | Per-mailbox interrupt routing |
| ld_start | input | 1 | Marks the first byte of a match-load burst |
| ld_valid | input | 1 | Load byte strobe |
| ld_byte | input | 8 | Load byte |
| match_rd | output | 24 | Readback of the three match registers |
| rx_valid | input | 1 | Accepted received word strobe |
| rx_word | input | 32 | Received word, label in [7:0] |
| rd_sel | input | 2 | Mailbox select (0 to 2) |
| rd_en | input | 1 | Consume the selected mailbox |
| box_data | output | 24 | Selected mailbox contents |
| box_rdy | output | 3 | Per-mailbox data-ready pins |
| irq | output | 1 | Masked OR of the ready flags |

## Verification
A stuck or misdirected load pointer shows up on `match_rd` one cycle after the offending byte. It then shows again as captures landing in the wrong mailbox or in none. A wrong hit decision, from a bad compare, a missed S/D check or an ignored enable, shows on `box_rdy` and `box_data` in the cycle right after `rx_valid`. The bench sweeps every label value under each filter setting to catch these. A wrong clear-versus-capture priority becomes visible only on a same-cycle collision, so that case is driven on purpose.

// File: rtl/plbox_pkg.sv
package plbox_pkg;
    localparam int LBL_W  = 8;
    localparam int WORD_W = 32;
    localparam int FLD_W  = WORD_W - LBL_W;
    localparam int SD_W   = 2;

    typedef logic [LBL_W-1:0] label_t;
    typedef logic [FLD_W-1:0] field_t;

    typedef struct packed {
        field_t field;
        label_t label;
    } rxword_t;

    // S/D bits sit directly above the label
    function automatic logic [SD_W-1:0] sd_of(rxword_t w);
        return w.field[SD_W-1:0];
    endfunction
endpackage

// File: rtl/plbox_loader.sv
module plbox_loader
    import plbox_pkg::*;
#(
    parameter int NBOX = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld_start,
    input  logic                  ld_valid,
    input  label_t                ld_byte,
    output logic [NBOX*LBL_W-1:0] match_flat
);
    localparam int PW = $clog2(NBOX + 1);
    localparam logic [PW-1:0] IDLE = PW'(NBOX);
    localparam logic [PW-1:0] TOP  = PW'(NBOX - 1);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] wr_idx;
    logic          wr_en;
    label_t        mreg_q [NBOX];

    always_comb begin
        wr_idx = ld_start ? TOP : ptr_q;
        wr_en  = ld_valid && (ld_start || ptr_q != IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= IDLE;
        end else if (wr_en) begin
            ptr_q <= (wr_idx == '0) ? IDLE : wr_idx - 1'b1;
        end else if (ld_start) begin
            ptr_q <= TOP;
        end
    end

    for (genvar i = 0; i < NBOX; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mreg_q[i] <= '0;
            end else if (wr_en && wr_idx == PW'(i)) begin
                mreg_q[i] <= ld_byte;
            end
        end
        assign match_flat[i*LBL_W +: LBL_W] = mreg_q[i];
    end

    AST_LOAD_FIRST_TOP: assert property (@(posedge clk) disable iff (rst)
        (ld_start && ld_valid) |=> (match_flat[(NBOX-1)*LBL_W +: LBL_W] == $past(ld_byte))); // R2
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ptr_q == IDLE && !ld_start) |=> $stable(match_flat)); // R2
endmodule

// File: rtl/plbox_gate.sv
module plbox_gate
    import plbox_pkg::*;
#(
    parameter int NBOX = 3
) (
    input  logic                  rx_valid,
    input  rxword_t               rx_word,
    input  logic                  cap_en,
    input  logic                  sd_en,
    input  logic [SD_W-1:0]       sd_val,
    input  logic [NBOX*LBL_W-1:0] match_flat,
    output logic [NBOX-1:0]       hit
);
    logic eligible;

    always_comb begin
        eligible = rx_valid && cap_en && (!sd_en || sd_of(rx_word) == sd_val);
    end

    for (genvar i = 0; i < NBOX; i++) begin : g_cmp
        assign hit[i] = eligible && (rx_word.label == match_flat[i*LBL_W +: LBL_W]);
    end
endmodule

// File: rtl/plbox_slot.sv
module plbox_slot
    import plbox_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hit,
    input  field_t din,
    input  logic   rd_clr,
    output logic   rdy,
    output field_t data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy  <= 1'b0;
            data <= '0;
        end else if (hit) begin
            rdy  <= 1'b1;
            data <= din;
        end else if (rd_clr) begin
            rdy  <= 1'b0;
        end
    end

    AST_HIT_SETS_RDY: assert property (@(posedge clk) disable iff (rst)
        hit |=> rdy); // R4
    AST_HIT_LOADS: assert property (@(posedge clk) disable iff (rst)
        hit |=> (data == $past(din))); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !hit) |=> !rdy); // R8
    AST_NO_HIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(data)); // R4
endmodule

// File: rtl/plbox_capture.sv
module plbox_capture
    import plbox_pkg::*;
#(
    parameter int NBOX = 3,
    localparam int SEL_W = $clog2(NBOX)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_cap_en,
    input  logic                  cfg_sd_en,
    input  logic [SD_W-1:0]       cfg_sd_val,
    input  logic [NBOX-1:0]       cfg_irq_mask,
    input  logic                  ld_start,
    input  logic                  ld_valid,
    input  logic [LBL_W-1:0]      ld_byte,
    output logic [NBOX*LBL_W-1:0] match_rd,
    input  logic                  rx_valid,
    input  logic [WORD_W-1:0]     rx_word,
    input  logic [SEL_W-1:0]      rd_sel,
    input  logic                  rd_en,
    output logic [FLD_W-1:0]      box_data,
    output logic [NBOX-1:0]       box_rdy,
    output logic                  irq
);
    rxword_t         word_s;
    logic [NBOX-1:0] hit;
    field_t          slot_data [NBOX];

    assign word_s = rxword_t'(rx_word);

    plbox_loader #(.NBOX(NBOX)) u_loader (
        .clk        (clk),
        .rst        (rst),
        .ld_start   (ld_start),
        .ld_valid   (ld_valid),
        .ld_byte    (ld_byte),
        .match_flat (match_rd)
    );

    plbox_gate #(.NBOX(NBOX)) u_gate (
        .rx_valid   (rx_valid),
        .rx_word    (word_s),
        .cap_en     (cfg_cap_en),
        .sd_en      (cfg_sd_en),
        .sd_val     (cfg_sd_val),
        .match_flat (match_rd),
        .hit        (hit)
    );

    for (genvar i = 0; i < NBOX; i++) begin : g_slot
        plbox_slot u_slot (
            .clk    (clk),
            .rst    (rst),
            .hit    (hit[i]),
            .din    (word_s.field),
            .rd_clr (rd_en && rd_sel == SEL_W'(i)),
            .rdy    (box_rdy[i]),
            .data   (slot_data[i])
        );
    end

    always_comb begin
        box_data = '0;
        for (int i = 0; i < NBOX; i++) begin
            if (rd_sel == SEL_W'(i)) box_data = slot_data[i];
        end
    end

    assign irq = |(box_rdy & cfg_irq_mask);

    AST_DISABLED_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        !cfg_cap_en |=> ((box_rdy & ~$past(box_rdy)) == '0)); // R5
    AST_SD_REJECT: assert property (@(posedge clk) disable iff (rst)
        (cfg_sd_en && rx_word[9:8] != cfg_sd_val) |=> ((box_rdy & ~$past(box_rdy)) == '0)); // R6
endmodule

// File: tb/plbox_capture_tb_top.sv
module plbox_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_cap_en, cfg_sd_en;
    logic [1:0]  cfg_sd_val;
    logic [2:0]  cfg_irq_mask;
    logic        ld_start, ld_valid;
    logic [7:0]  ld_byte;
    logic [23:0] match_rd;
    logic        rx_valid;
    logic [31:0] rx_word;
    logic [1:0]  rd_sel;
    logic        rd_en;
    logic [23:0] box_data;
    logic [2:0]  box_rdy;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  m_match [3];
    logic [23:0] m_data  [3];
    logic [2:0]  m_rdy;

    always #4 clk = ~clk;

    plbox_capture dut_i (
        .clk(clk), .rst(rst), .cfg_cap_en(cfg_cap_en), .cfg_sd_en(cfg_sd_en),
        .cfg_sd_val(cfg_sd_val), .cfg_irq_mask(cfg_irq_mask), .ld_start(ld_start),
        .ld_valid(ld_valid), .ld_byte(ld_byte), .match_rd(match_rd),
        .rx_valid(rx_valid), .rx_word(rx_word), .rd_sel(rd_sel), .rd_en(rd_en),
        .box_data(box_data), .box_rdy(box_rdy), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R3 match_rd"}, 32'(match_rd), {8'h0, m_match[2], m_match[1], m_match[0]});
        chk({tag, " R4 box_rdy"}, 32'(box_rdy), 32'(m_rdy));
        chk({tag, " R11 irq"}, 32'(irq), 32'(|(m_rdy & cfg_irq_mask)));
        for (int i = 0; i < 3; i++) begin
            rd_sel = 2'(i);
            #1;
            chk({tag, " R8 box_data"}, 32'(box_data), 32'(m_data[i]));
        end
    endtask

    // called just after a negedge; returns just after the next negedge
    task automatic send(input logic [31:0] w, input logic rd, input int ri);
        logic elig;
        rx_valid = 1'b1; rx_word = w; rd_en = rd; rd_sel = 2'(ri);
        @(negedge clk);
        rx_valid = 1'b0; rd_en = 1'b0;
        elig = cfg_cap_en && (!cfg_sd_en || w[9:8] == cfg_sd_val);
        for (int i = 0; i < 3; i++) begin
            if (elig && w[7:0] == m_match[i]) begin
                m_rdy[i] = 1'b1; m_data[i] = w[31:8];
            end else if (rd && ri == i) begin
                m_rdy[i] = 1'b0;
            end
        end
    endtask

    task automatic load3(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic extra);
        ld_start = 1'b1; ld_valid = 1'b1; ld_byte = b0;
        @(negedge clk);
        ld_start = 1'b0; ld_byte = b1;
        @(negedge clk);
        ld_byte = b2;
        @(negedge clk);
        if (extra) begin
            ld_byte = ~b2;
            @(negedge clk);
        end
        ld_valid = 1'b0;
        m_match[2] = b0; m_match[1] = b1; m_match[0] = b2;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_cap_en = 0; cfg_sd_en = 0; cfg_sd_val = 0; cfg_irq_mask = 0;
        ld_start = 0; ld_valid = 0; ld_byte = 0; rx_valid = 0; rx_word = 0;
        rd_sel = 0; rd_en = 0;
        for (int i = 0; i < 3; i++) begin m_match[i] = 0; m_data[i] = 0; end
        m_rdy = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // R2: load order, extra byte ignored
        load3(8'h3C, 8'hA5, 8'h17, 1'b1);
        check_all("R2 load");

        // R4 R7 R8 R9 R11: all labels, capture enabled, no S/D filter
        cfg_cap_en = 1; cfg_irq_mask = 3'b101;
        load3(8'h3C, 8'hA5, 8'h3C, 1'b0);
        for (int l = 0; l < 256; l++) begin
            send({22'(l * 977 + 5), 2'(l), 8'(l)}, (l % 4) == 0, l % 3);
            check_all("R4 R7 sweep");
        end
        // R9: overwrite while full
        send({24'hABCDE1, 8'hA5}, 1'b0, 0);
        send({24'h123457, 8'hA5}, 1'b0, 0);
        check_all("R9 overwrite");
        // R8: consume each mailbox
        for (int i = 0; i < 3; i++) begin
            send(32'h0000_00FF, 1'b1, i);
            check_all("R8 read clear");
        end

        // R6: S/D filter on
        cfg_sd_en = 1; cfg_irq_mask = 3'b010;
        for (int v = 0; v < 4; v++) begin
            cfg_sd_val = 2'(v);
            for (int s = 0; s < 4; s++) begin
                send({22'(v * 31 + s), 2'(s), 8'hA5}, 1'b1, 2);
                check_all("R6 sd filter");
                send({22'(v * 7 + s), 2'(s), 8'h3C}, 1'b1, 1);
                check_all("R6 sd filter");
            end
        end
        cfg_sd_en = 0;

        // R10: capture and read of the same mailbox in one cycle
        send({24'h0F0F01, 8'hA5}, 1'b0, 0);
        send({24'h5A5A02, 8'hA5}, 1'b1, 1);
        check_all("R10 collide");

        // R5: capture disabled, sweep all labels
        cfg_cap_en = 0; cfg_irq_mask = 3'b111;
        send(32'h0000_00FF, 1'b1, 1);
        for (int l = 0; l < 256; l++) begin
            send({22'(l + 9), 2'(l), 8'(l)}, 1'b0, 0);
            if ((l % 32) == 0) check_all("R5 disabled");
        end
        check_all("R5 disabled end");

        // R3 R2: reload with three distinct values, then capture again
        load3(8'h01, 8'h02, 8'h03, 1'b0);
        check_all("R3 reload");
        cfg_cap_en = 1;
        for (int l = 1; l < 4; l++) begin
            send({24'(l * 4097), 8'(l)}, 1'b0, 0);
            check_all("R4 distinct");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule